// File: doc/BRIEF.md
# Clock Output Stop Gating Controller

This block sits between the running source clocks of a multi-output clock generator and its output pins. For every output it decides, on each cycle, whether the output follows its source clock, is parked at a fixed logic level, or is placed in a power-down state. The decision depends on three active-low control pins (CPU-stop, PCI-stop, power-down) and on configuration bits held in a register bank elsewhere: per-output enables, per-output free-running selects, a pin-ignore mask, two power-down mode bits and per-group invert bits.

The outputs are organised in groups. There are three differential CPU pairs, seven stoppable PCI outputs, three PCIF outputs, four 66 MHz outputs, three 66-out outputs, and one output each of VCH, USB and DOT. All of the logic runs on one sampling clock `clk`. The source clocks arrive as level signals sampled on that clock, and every gated output is registered. Each CPU pair also reports a 2-bit drive-state code, which tells the analog current driver how to hold a parked pair. The control pins pass through two-flop synchronizers. A gate opens or closes only in a cycle where the source sits at the output's park level, so no shortened pulse can appear.

Top module: `clkStopGate`

## Requirements
- R1: While reset is active, every single-ended output is low. Each CPU pair has its true output high and its complement low, and its drive code is 01. This assumes all invert bits are 0.
- R2: A control-pin change has no effect on the outputs during the first two clock edges after it. Whenever an output changes value (with its invert bit steady), the new value equals its source clock as sampled at that edge, so stopping or restarting never cuts a pulse short.
- R3: While CPU-stop acts, an enabled pair whose free-run select is 0 parks with true high and complement low. Its code is 01 when pdMode is 00 and 11 otherwise. A pair whose select is 1 keeps running with code 00. A running pair always reports code 00.
- R4: pciStopStatus is the synchronized PCI-stop pin ANDed with pciStopBit. PCI-stop acts when pciStopBit is 0, or when the pin is low and not masked.
- R5: While PCI-stop acts, a PCI output whose pciFree bit is 0 stops low. A PCI output whose pciFree bit is 1 keeps running.
- R6: The PCIF control bits have the opposite sense. A bit of 1 makes that output stop low under PCI-stop, and a bit of 0 makes it run freely.
- R7: A disabled single-ended output is held low. A disabled CPU pair parks with true high and complement low, with code 01, when power-down is not acting.
- R8: While power-down acts, every single-ended output is low and every pair parks split. This holds whatever the enables and stops are. A stoppable pair reports 10 when pdMode is 00 and 11 otherwise. A free-running pair reports 10 when pdMode[1] is 0 and 11 when it is 1.
- R9: Setting a pinMask bit makes the block ignore the matching pin. Bit 0 is power-down, bit 1 is CPU-stop and bit 2 is PCI-stop. A bit of 0 lets the pin act.
- R10: An invert bit, when set, inverts the final output of its group, including the park level. Bit 0 is CPU (it swaps true and complement), bit 1 is the 66 group, bit 2 is the 66-out group, bit 3 is PCI and PCIF, bit 4 is VCH, bit 5 is USB and bit 6 is DOT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for all logic |
| rstN | input | 1 | Asynchronous active-low reset |
| cpuSrc | input | 1 | Source clock level for the CPU pairs |
| src66 | input | 1 | Source clock level for the 66 and 66-out groups |
| pciSrc | input | 1 | Source clock level for the PCI and PCIF outputs |
| src48 | input | 1 | Source clock level for VCH, USB and DOT |
| cpuStopN | input | 1 | Asynchronous active-low CPU-stop pin |
| pciStopN | input | 1 | Asynchronous active-low PCI-stop pin |
| pwrDnN | input | 1 | Asynchronous active-low power-down pin |
| cpuEn | input | 3 | Per-pair enable |
| cpuFree | input | 3 | Per-pair free-run select (1 ignores CPU-stop) |
| pciEn | input | 7 | Per-output PCI enable |
| pciFree | input | 7 | Per-output PCI free-run select (1 ignores PCI-stop) |
| pcifEn | input | 3 | Per-output PCIF enable |
| pcifStoppable | input | 3 | Per-output PCIF stop select (1 obeys PCI-stop) |
| en66 | input | 4 | 66 group enables |
| en66Out | input | 3 | 66-out group enables |
| vchEn | input | 1 | VCH enable |
| usbEn | input | 1 | USB enable |
| dotEn | input | 1 | DOT enable |
| pciStopBit | input | 1 | Register half of the PCI-stop AND |
| pinMask | input | 3 | Pin ignore mask (bit0 power-down, bit1 CPU-stop, bit2 PCI-stop) |
| pdMode | input | 2 | Power-down mode bits for the CPU pairs |
| invSel | input | 7 | Per-group invert bits |
| cpuT | output | 3 | CPU pair true outputs |
| cpuC | output | 3 | CPU pair complement outputs |
| cpuDrv | output | 6 | Drive code per pair, pair i in bits 2i+1:2i (00 run, 01 park 6x, 10 park 2x, 11 high-impedance) |
| pciOut | output | 7 | Gated PCI outputs |
| pcifOut | output | 3 | Gated PCIF outputs |
| out66 | output | 4 | Gated 66 group outputs |
| out66Out | output | 3 | Gated 66-out group outputs |
| vchOut | output | 1 | Gated VCH output |
| usbOut | output | 1 | Gated USB output |
| dotOut | output | 1 | Gated DOT output |
| pciStopStatus | output | 1 | Read-back of the internal PCI-stop AND |

## Verification
The assertions check four properties on every cycle. A PCI or CPU output may change only to the source value sampled at that edge, which is the no-runt rule. A pair reporting a non-zero drive code must sit at its split park level. The PCI-stop status can be 1 only if both the register bit and the pin, as it was two edges earlier, are 1. The bench scenarios cover the properties that depend on combinations of settings: the PCI and PCIF free-run senses, the drive codes under each power-down mode, the priority of power-down over enables and stops, the pin masks, the two-edge pin latency, and the invert bits.

// File: rtl/clk_gate_pkg.sv
package clk_gate_pkg;
  localparam int NCPU   = 3;
  localparam int NPCI   = 7;
  localparam int NPCIF  = 3;
  localparam int N66    = 4;
  localparam int N66OUT = 3;
  localparam int NMISC  = 3;
  localparam int NSE    = NPCI + NPCIF + N66 + N66OUT + NMISC;
  localparam int NPIN   = 3;
  localparam int NINV   = 7;

  typedef enum logic [1:0] {
    DRV_RUN   = 2'b00,
    DRV_PARK6 = 2'b01,
    DRV_PARK2 = 2'b10,
    DRV_OFF   = 2'b11
  } drvCode_t;

  typedef struct packed {
    logic [NSE-1:0]    seRun;
    logic [NCPU-1:0]   cpuRun;
    logic [2*NCPU-1:0] cpuPark;
  } gateStrobe_t;
endpackage

// File: rtl/clkGateCtrl.sv
module clkGateCtrl
  import clk_gate_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuStopN,
  input  logic              pciStopN,
  input  logic              pwrDnN,
  input  logic [NCPU-1:0]   cpuEn,
  input  logic [NCPU-1:0]   cpuFree,
  input  logic [NSE-1:0]    seEn,
  input  logic [NPCI-1:0]   pciFree,
  input  logic [NPCIF-1:0]  pcifStoppable,
  input  logic              pciStopBit,
  input  logic [NPIN-1:0]   pinMask,
  input  logic [1:0]        pdMode,
  output gateStrobe_t       strobe,
  output logic              pciStopStatus
);
  localparam int NFREE = NSE - NPCI - NPCIF;

  logic [NPIN-1:0] pinsN, syncA, syncB;
  assign pinsN = {pciStopN, cpuStopN, pwrDnN};

  // two-flop synchronizer per control pin, reset to the inactive level
  for (genvar p = 0; p < NPIN; p++) begin : g_sync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncA[p] <= 1'b1;
        syncB[p] <= 1'b1;
      end else begin
        syncA[p] <= pinsN[p];
        syncB[p] <= syncA[p];
      end
    end
  end

  logic pdAct, cpuStopAct, pciStopAct;
  logic [NSE-1:0] seHold;

  assign pdAct         = ~pinMask[0] & ~syncB[0];
  assign cpuStopAct    = ~pinMask[1] & ~syncB[1];
  assign pciStopAct    = ~pciStopBit | (~pinMask[2] & ~syncB[2]);
  assign pciStopStatus = syncB[2] & pciStopBit;
  assign seHold        = {{NFREE{1'b1}}, ~pcifStoppable, pciFree};

  always_comb begin
    drvCode_t code;
    strobe.seRun = {NSE{~pdAct}} & seEn & (seHold | {NSE{~pciStopAct}});
    for (int i = 0; i < NCPU; i++) begin
      strobe.cpuRun[i] = ~pdAct & cpuEn[i] & (cpuFree[i] | ~cpuStopAct);
      if (pdAct) begin
        if (cpuFree[i]) code = pdMode[1] ? DRV_OFF : DRV_PARK2;
        else            code = (pdMode == 2'b00) ? DRV_PARK2 : DRV_OFF;
      end else if (!cpuEn[i]) begin
        code = DRV_PARK6;
      end else begin
        code = (pdMode == 2'b00) ? DRV_PARK6 : DRV_OFF;
      end
      strobe.cpuPark[2*i +: 2] = code;
    end
  end
endmodule

// File: rtl/clkGateDp.sv
module clkGateDp
  import clk_gate_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  gateStrobe_t       strobe,
  input  logic [NSE-1:0]    srcSe,
  input  logic [NSE-1:0]    invSe,
  input  logic              cpuSrc,
  input  logic              invCpu,
  output logic [NSE-1:0]    seOut,
  output logic [NCPU-1:0]   cpuT,
  output logic [NCPU-1:0]   cpuC,
  output logic [2*NCPU-1:0] cpuDrv
);
  logic [NSE-1:0]    seRunQ, seQ, seNext;
  logic [NCPU-1:0]   cpuRunQ, tQ, cpuNext;
  logic [2*NCPU-1:0] parkQ;

  // gate state may only move while the source sits at the park level
  assign seNext  = (~srcSe & strobe.seRun) | (srcSe & seRunQ);
  assign cpuNext = ({NCPU{cpuSrc}} & strobe.cpuRun) | ({NCPU{~cpuSrc}} & cpuRunQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seRunQ  <= '0;
      seQ     <= '0;
      cpuRunQ <= '0;
      tQ      <= '1;
      for (int i = 0; i < NCPU; i++) parkQ[2*i +: 2] <= DRV_PARK6;
    end else begin
      seRunQ  <= seNext;
      seQ     <= seNext & srcSe;
      cpuRunQ <= cpuNext;
      tQ      <= ~cpuNext | {NCPU{cpuSrc}};
      parkQ   <= strobe.cpuPark;
    end
  end

  for (genvar i = 0; i < NCPU; i++) begin : g_drv
    assign cpuDrv[2*i +: 2] = cpuRunQ[i] ? DRV_RUN : parkQ[2*i +: 2];
  end

  assign seOut = seQ ^ invSe;
  assign cpuT  = tQ ^ {NCPU{invCpu}};
  assign cpuC  = ~tQ ^ {NCPU{invCpu}};
endmodule

// File: rtl/clkStopGate.sv
module clkStopGate
  import clk_gate_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuSrc,
  input  logic              src66,
  input  logic              pciSrc,
  input  logic              src48,
  input  logic              cpuStopN,
  input  logic              pciStopN,
  input  logic              pwrDnN,
  input  logic [NCPU-1:0]   cpuEn,
  input  logic [NCPU-1:0]   cpuFree,
  input  logic [NPCI-1:0]   pciEn,
  input  logic [NPCI-1:0]   pciFree,
  input  logic [NPCIF-1:0]  pcifEn,
  input  logic [NPCIF-1:0]  pcifStoppable,
  input  logic [N66-1:0]    en66,
  input  logic [N66OUT-1:0] en66Out,
  input  logic              vchEn,
  input  logic              usbEn,
  input  logic              dotEn,
  input  logic              pciStopBit,
  input  logic [NPIN-1:0]   pinMask,
  input  logic [1:0]        pdMode,
  input  logic [NINV-1:0]   invSel,
  output logic [NCPU-1:0]   cpuT,
  output logic [NCPU-1:0]   cpuC,
  output logic [2*NCPU-1:0] cpuDrv,
  output logic [NPCI-1:0]   pciOut,
  output logic [NPCIF-1:0]  pcifOut,
  output logic [N66-1:0]    out66,
  output logic [N66OUT-1:0] out66Out,
  output logic              vchOut,
  output logic              usbOut,
  output logic              dotOut,
  output logic              pciStopStatus
);
  localparam int OFF_PCIF = NPCI;
  localparam int OFF_66   = OFF_PCIF + NPCIF;
  localparam int OFF_66O  = OFF_66 + N66;
  localparam int OFF_VCH  = OFF_66O + N66OUT;

  gateStrobe_t    strobe;
  logic [NSE-1:0] seEn, seSrc, seInv, seOut;

  assign seEn  = {dotEn, usbEn, vchEn, en66Out, en66, pcifEn, pciEn};
  assign seSrc = {src48, src48, src48, {N66OUT{src66}}, {N66{src66}},
                  {NPCIF{pciSrc}}, {NPCI{pciSrc}}};
  assign seInv = {invSel[6], invSel[5], invSel[4], {N66OUT{invSel[2]}},
                  {N66{invSel[1]}}, {NPCIF{invSel[3]}}, {NPCI{invSel[3]}}};

  clkGateCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .cpuStopN(cpuStopN), .pciStopN(pciStopN),
    .pwrDnN(pwrDnN), .cpuEn(cpuEn), .cpuFree(cpuFree), .seEn(seEn),
    .pciFree(pciFree), .pcifStoppable(pcifStoppable), .pciStopBit(pciStopBit),
    .pinMask(pinMask), .pdMode(pdMode), .strobe(strobe),
    .pciStopStatus(pciStopStatus)
  );

  clkGateDp u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .srcSe(seSrc), .invSe(seInv),
    .cpuSrc(cpuSrc), .invCpu(invSel[0]), .seOut(seOut), .cpuT(cpuT),
    .cpuC(cpuC), .cpuDrv(cpuDrv)
  );

  assign pciOut   = seOut[0 +: NPCI];
  assign pcifOut  = seOut[OFF_PCIF +: NPCIF];
  assign out66    = seOut[OFF_66 +: N66];
  assign out66Out = seOut[OFF_66O +: N66OUT];
  assign vchOut   = seOut[OFF_VCH];
  assign usbOut   = seOut[OFF_VCH + 1];
  assign dotOut   = seOut[OFF_VCH + 2];
endmodule

// File: rtl/clkGateChk.sv
module clkGateChk
  import clk_gate_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              cpuSrc,
  input logic              pciSrc,
  input logic              pciStopN,
  input logic              pciStopBit,
  input logic [NINV-1:0]   invSel,
  input logic [NPCI-1:0]   pciOut,
  input logic [NCPU-1:0]   cpuT,
  input logic [NCPU-1:0]   cpuC,
  input logic [2*NCPU-1:0] cpuDrv,
  input logic              pciStopStatus
);
  logic [1:0] upCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) upCnt <= '0;
    else if (upCnt != 2'd3) upCnt <= upCnt + 2'd1;
  end

  AST_PCI_NO_RUNT: assert property (@(posedge clk) disable iff (!rstN)
    $stable(invSel[3]) |->
      ((pciOut ^ $past(pciOut)) & (pciOut ^ {NPCI{$past(pciSrc) ^ invSel[3]}})) == '0); // R2

  AST_CPU_NO_RUNT: assert property (@(posedge clk) disable iff (!rstN)
    $stable(invSel[0]) |->
      ((cpuT ^ $past(cpuT)) & (cpuT ^ {NCPU{$past(cpuSrc) ^ invSel[0]}})) == '0); // R2

  for (genvar i = 0; i < NCPU; i++) begin : g_split
    AST_CPU_SPLIT: assert property (@(posedge clk) disable iff (!rstN)
      (cpuDrv[2*i +: 2] != 2'b00) |-> (cpuT[i] == ~invSel[0]) && (cpuC[i] == invSel[0])); // R3
  end

  AST_PCI_STATUS_AND: assert property (@(posedge clk) disable iff (!rstN)
    (upCnt == 2'd3) && pciStopStatus |-> pciStopBit && $past(pciStopN, 2)); // R4
endmodule

bind clkStopGate clkGateChk u_chk (.*);

// File: tb/clkStopGate_tb.sv
module clkStopGate_tb;
  import clk_gate_pkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cpuSrc = 0, src66 = 0, pciSrc = 0, src48 = 0;
  logic cpuStopN = 1, pciStopN = 1, pwrDnN = 1;
  logic [NCPU-1:0]   cpuEn, cpuFree;
  logic [NPCI-1:0]   pciEn, pciFree;
  logic [NPCIF-1:0]  pcifEn, pcifStoppable;
  logic [N66-1:0]    en66;
  logic [N66OUT-1:0] en66Out;
  logic vchEn, usbEn, dotEn, pciStopBit;
  logic [NPIN-1:0]   pinMask;
  logic [1:0]        pdMode;
  logic [NINV-1:0]   invSel;
  logic [NCPU-1:0]   cpuT, cpuC;
  logic [2*NCPU-1:0] cpuDrv;
  logic [NPCI-1:0]   pciOut;
  logic [NPCIF-1:0]  pcifOut;
  logic [N66-1:0]    out66;
  logic [N66OUT-1:0] out66Out;
  logic vchOut, usbOut, dotOut, pciStopStatus;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  clkStopGate u_dut (.*);

  task automatic check(string tag, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic advSrc();
    cyc++;
    cpuSrc = cyc[0];
    src66  = cyc[1];
    pciSrc = cyc[2];
    src48  = (cyc % 6) < 3;
  endtask

  task automatic defaults();
    cpuEn = '1; cpuFree = '0; pciEn = '1; pciFree = '0;
    pcifEn = '1; pcifStoppable = '0; en66 = '1; en66Out = '1;
    vchEn = 1; usbEn = 1; dotEn = 1; pciStopBit = 1;
    pinMask = '0; pdMode = '0; invSel = '0;
    cpuStopN = 1; pciStopN = 1; pwrDnN = 1;
  endtask

  function automatic logic pdA();  return !pinMask[0] && !pwrDnN;  endfunction
  function automatic logic cpuA(); return !pinMask[1] && !cpuStopN; endfunction
  function automatic logic pciA(); return !pciStopBit || (!pinMask[2] && !pciStopN); endfunction

  function automatic logic [1:0] expCode(int i);
    if (!pdA() && cpuEn[i] && (cpuFree[i] || !cpuA())) return 2'b00;
    if (pdA()) begin
      if (cpuFree[i]) return pdMode[1] ? 2'b11 : 2'b10;
      return (pdMode == 2'b00) ? 2'b10 : 2'b11;
    end
    if (!cpuEn[i]) return 2'b01;
    return (pdMode == 2'b00) ? 2'b01 : 2'b11;
  endfunction

  // settle, then compare every group over a window of cycles
  task automatic runCheck(string tag);
    logic [NCPU-1:0] eT, eC, aT, aC;
    logic [2*NCPU-1:0] eD, aD;
    logic [NPCI-1:0] eP, aP;
    logic [NPCIF-1:0] eF, aF;
    logic [N66-1:0] e6, a6;
    logic [N66OUT-1:0] eO, aO;
    logic [2:0] eM, aM;
    logic eS, aS;
    logic [10:0] bad;
    repeat (12) begin @(negedge clk); advSrc(); end
    bad = '0;
    repeat (8) begin
      @(negedge clk);
      for (int i = 0; i < NCPU; i++) begin
        logic t;
        t = (expCode(i) == 2'b00) ? cpuSrc : 1'b1;
        eT[i] = t ^ invSel[0];
        eC[i] = ~t ^ invSel[0];
        eD[2*i +: 2] = expCode(i);
      end
      for (int i = 0; i < NPCI; i++)
        eP[i] = (!pdA() && pciEn[i] && (pciFree[i] || !pciA()) && pciSrc) ^ invSel[3];
      for (int i = 0; i < NPCIF; i++)
        eF[i] = (!pdA() && pcifEn[i] && (!pcifStoppable[i] || !pciA()) && pciSrc) ^ invSel[3];
      for (int i = 0; i < N66; i++) e6[i] = (!pdA() && en66[i] && src66) ^ invSel[1];
      for (int i = 0; i < N66OUT; i++) eO[i] = (!pdA() && en66Out[i] && src66) ^ invSel[2];
      eM[0] = (!pdA() && vchEn && src48) ^ invSel[4];
      eM[1] = (!pdA() && usbEn && src48) ^ invSel[5];
      eM[2] = (!pdA() && dotEn && src48) ^ invSel[6];
      eS = pciStopN & pciStopBit;
      aT = cpuT; aC = cpuC; aD = cpuDrv; aP = pciOut; aF = pcifOut;
      a6 = out66; aO = out66Out; aM = {dotOut, usbOut, vchOut}; aS = pciStopStatus;
      if (aT !== eT) bad[0] = 1;
      if (aC !== eC) bad[1] = 1;
      if (aD !== eD) bad[2] = 1;
      if (aP !== eP) bad[3] = 1;
      if (aF !== eF) bad[4] = 1;
      if (a6 !== e6) bad[5] = 1;
      if (aO !== eO) bad[6] = 1;
      if (aM !== eM) bad[7] = 1;
      if (aS !== eS) bad[8] = 1;
      if (bad[8:0] != 0 && !bad[10]) begin
        bad[10] = 1;
        check(tag, "cpuT", 16'(aT), 16'(eT));
        check(tag, "cpuC", 16'(aC), 16'(eC));
        check(tag, "cpuDrv", 16'(aD), 16'(eD));
        check(tag, "pciOut", 16'(aP), 16'(eP));
        check(tag, "pcifOut", 16'(aF), 16'(eF));
        check(tag, "out66", 16'(a6), 16'(e6));
        check(tag, "out66Out", 16'(aO), 16'(eO));
        check(tag, "misc48", 16'(aM), 16'(eM));
        check(tag, "status", 16'(aS), 16'(eS));
      end
      advSrc();
    end
    if (!bad[10]) begin
      check(tag, "cpu pairs", 16'(bad[2:0]), 16'd0);
      check(tag, "pci groups", 16'(bad[4:3]), 16'd0);
      check(tag, "66 groups", 16'(bad[6:5]), 16'd0);
      check(tag, "48 group and status", 16'(bad[8:7]), 16'd0);
    end
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h1a2b3c4d));
    defaults();
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "cpuT", 16'(cpuT), 16'h7);
    check("R1", "cpuC", 16'(cpuC), 16'h0);
    check("R1", "cpuDrv", 16'(cpuDrv), 16'h15);
    check("R1", "single-ended", 16'({pciOut, pcifOut, out66, out66Out, vchOut, usbOut, dotOut} != 0), 16'd0);
    rstN = 1;
    runCheck("R7 default");

    // R2: pin latency of two edges
    cpuStopN = 0;
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      check("R2", "cpuT during sync", 16'(cpuT), {13'd0, {3{cpuSrc}}});
      advSrc();
    end
    runCheck("R3 stop all");
    cpuFree = 3'b010; runCheck("R3 mixed free");
    pdMode = 2'b01; runCheck("R3 hiz code");
    defaults();

    pciStopN = 0; pciFree = 7'b1010101; pcifStoppable = 3'b101;
    runCheck("R5 R6 pin stop");
    pciStopN = 1; pciStopBit = 0; runCheck("R4 bit stop");
    defaults();

    cpuEn = 3'b101; pciEn = 7'b0110011; en66 = 4'b1001; usbEn = 0;
    runCheck("R7 disables");
    defaults();

    pwrDnN = 0; cpuFree = 3'b100; cpuStopN = 0; cpuEn = 3'b011;
    runCheck("R8 mode00");
    pdMode = 2'b10; runCheck("R8 mode10");
    pdMode = 2'b01; runCheck("R8 mode01");
    defaults();

    pinMask = 3'b111; pwrDnN = 0; cpuStopN = 0; pciStopN = 0;
    runCheck("R9 all masked");
    pinMask = 3'b010; runCheck("R9 partial mask");
    defaults();

    invSel = 7'h7f; cpuStopN = 0; cpuFree = 3'b001; pciStopN = 0;
    runCheck("R10 invert");
    defaults();

    for (int n = 0; n < 30; n++) begin
      cpuEn = NCPU'($urandom); cpuFree = NCPU'($urandom);
      pciEn = NPCI'($urandom); pciFree = NPCI'($urandom);
      pcifEn = NPCIF'($urandom); pcifStoppable = NPCIF'($urandom);
      en66 = N66'($urandom); en66Out = N66OUT'($urandom);
      {vchEn, usbEn, dotEn} = 3'($urandom);
      pciStopBit = ($urandom % 4) != 0;
      pinMask = NPIN'($urandom); pdMode = 2'($urandom); invSel = NINV'($urandom);
      cpuStopN = $urandom; pciStopN = $urandom; pwrDnN = ($urandom % 3) != 0;
      runCheck("R3 R4 R5 R6 R7 R8 R9 R10 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule